// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a UART with a small register window. Software programs a 12-bit baud divisor, picks normal or double-speed oversampling, and sets the character format. The format takes 5 to 9 data bits, no parity, even parity or odd parity, and one or two stop bits. A byte written to the data register waits in a one-deep holding register until the transmit shifter is free. Received characters are placed in a receive holding register, together with their error flags.

Six status flags are kept: receive ready, transmit holding empty, transmit finished, framing error, overrun and parity error. Each flag has its own interrupt enable, and the single interrupt output is active while any enabled flag is set. The transmit-finished flag is only set when the line has gone quiet, so software can use it to turn a half-duplex line driver around. It is cleared either by a write-one to it or by an acknowledge pulse from an interrupt controller.

Top module: `uart_core`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, the committed divisor is 0, both directions are disabled, and STATUS reads 0x02.
- R2: One bit lasts 16*(D+1) clocks, or 8*(D+1) clocks when FORMAT bit 6 (double speed) is 1. D is the 12-bit divisor. A write to DIVHI (address 4, bits 3:0) only stages the top four bits. A write to DIVLO (address 5) commits {staged, wrData}. DIVHI reads back the committed top bits.
- R3: A frame starts with a 0 start bit, followed by the data bits LSB first. FORMAT bits 2:0 select the size: 000=5, 001=6, 010=7, 011=8, 111=9 bits. Codes 100 to 110 behave as 8 bits.
- R4: FORMAT bits 4:3 select parity: 10=even and 11=odd, sent after the data bits. 00 and 01 send no parity bit. FORMAT bit 5 selects two stop bits (1) or one (0). Stop bits are 1.
- R5: STATUS bit 1 (transmit holding empty) goes to 0 when DATA (address 0) is written. It returns to 1 when the shifter takes the byte. A second byte can wait while the first one is on the line.
- R6: STATUS bit 2 (transmit finished) is set when the last stop bit ends and no byte is waiting. It is cleared by writing STATUS with bit 2 set, or by a one-cycle pulse on `txDoneAck`.
- R7: The receiver samples each bit as the majority of three oversampling ticks around mid-bit. A complete character sets STATUS bit 0 (receive ready). Reading DATA returns the low 8 bits and clears receive ready.
- R8: In 9-bit mode, the ninth transmit bit is FORMAT bit 7 as it stands when DATA is written. The ninth received bit reads as STATUS bit 6; it is 0 for shorter sizes.
- R9: STATUS bit 3 is set when the first stop bit is sampled as 0. Like the other error flags, it is rewritten each time a character is accepted.
- R10: STATUS bit 5 is set when parity is enabled and the received parity bit does not match.
- R11: If a character completes while receive ready is still set, STATUS bit 4 (overrun) is set and the new character is dropped, so the unread one is kept. The next accepted character clears overrun.
- R12: A low pulse that is high again at mid start bit is rejected and delivers no character.
- R13: IEN (address 2) bits 5:0 enable the STATUS flags at the same positions. `irq` is the OR of the enabled, set flags.
- R14: ENABLE (address 6) bit 0 enables the receiver and bit 1 enables the transmitter. With the receiver disabled, line activity is ignored. With the transmitter disabled, a written byte stays held and `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (DATA read side effect) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `addr` |
| txDoneAck | input | 1 | Clears transmit-finished when an interrupt is serviced |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep loops the transmit line back to the receiver. It runs every size code, including a reserved one, with all four parity codes, both stop counts and both oversampling rates. Each frame's waveform is compared bit by bit with a frame built in the bench, which separates errors in data order, parity polarity and stop count from errors in bit timing. The receive side is then driven directly with frames carrying a bad stop bit, a bad parity bit, frames sent back to back with no read in between, and a short low glitch. These patterns separate framing, parity, overrun and false-start handling. Back-to-back writes and a disabled transmitter show that the holding-empty and transmit-finished flags behave as two separate flags.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DIV_W   = 12;
  localparam int WORD_W  = 9;
  localparam int FRAME_W = WORD_W + 4;
  localparam int ADDR_W  = 3;
  localparam int NFLAGS  = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA   = 3'd0,
    A_STATUS = 3'd1,
    A_IEN    = 3'd2,
    A_FORMAT = 3'd3,
    A_DIVHI  = 3'd4,
    A_DIVLO  = 3'd5,
    A_ENABLE = 3'd6
  } regAddr_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             dbl;
    logic [3:0]       nBits;
    logic [1:0]       parMode;
    logic             twoStop;
    logic             rxEn;
  } lineCfg_t;

  typedef struct packed {
    logic              txReq;
    logic [WORD_W-1:0] txWord;
  } ctrlStb_t;

  typedef struct packed {
    logic              rxDone;
    logic [WORD_W-1:0] rxWord;
    logic              rxFrameErr;
    logic              rxParErr;
    logic              txTaken;
    logic              txEnd;
  } dpStb_t;

  function automatic logic [3:0] decodeSize(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic wordParity(input logic [WORD_W-1:0] w, input logic [3:0] n,
                                      input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(n)) p = p ^ w[i];
    end
    return p;
  endfunction
endpackage

// File: rtl/uart_datapath.sv
module uart_datapath
  import uart_pkg::*;
#(
  parameter int OVS_NORM = 16,
  parameter int OVS_FAST = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  lineCfg_t cfg,
  input  ctrlStb_t cStb,
  output dpStb_t   dStb,
  input  logic     rxd,
  output logic     txd
);
  localparam int CNT_W = $clog2(OVS_NORM);

  logic [CNT_W-1:0] ovsLast, midPt;
  assign ovsLast = cfg.dbl ? CNT_W'(OVS_FAST - 1) : CNT_W'(OVS_NORM - 1);
  assign midPt   = cfg.dbl ? CNT_W'(OVS_FAST / 2) : CNT_W'(OVS_NORM / 2);

  // oversampling tick
  logic [DIV_W-1:0] preCnt;
  logic tick;
  assign tick = (preCnt == '0);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= tick ? cfg.div : preCnt - 1'b1;
  end

  logic parOn;
  assign parOn = cfg.parMode[1];

  // transmit frame assembly
  logic [FRAME_W-1:0] txFrame;
  logic [3:0]         txLen;
  always_comb begin
    txLen   = 4'd2 + cfg.nBits + {3'd0, parOn} + {3'd0, cfg.twoStop};
    txFrame = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(cfg.nBits)) txFrame[i+1] = cStb.txWord[i];
    end
    if (parOn) txFrame[cfg.nBits + 4'd1] = wordParity(cStb.txWord, cfg.nBits, cfg.parMode[0]);
  end

  logic               txBusy;
  logic [FRAME_W-1:0] txShift;
  logic [3:0]         txLeft;
  logic [CNT_W-1:0]   txCnt;
  logic txBitEnd, txLastEnd, txLoad;
  assign txBitEnd  = txBusy && tick && (txCnt == ovsLast);
  assign txLastEnd = txBitEnd && (txLeft == 4'd0);
  assign txLoad    = cStb.txReq && (!txBusy || txLastEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txShift <= '1;
      txLeft  <= '0;
      txCnt   <= '0;
    end else if (txLoad) begin
      txBusy  <= 1'b1;
      txShift <= txFrame;
      txLeft  <= txLen - 4'd1;
      txCnt   <= '0;
    end else if (txLastEnd) begin
      txBusy <= 1'b0;
    end else if (txBusy && tick) begin
      if (txBitEnd) begin
        txCnt   <= '0;
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
        txLeft  <= txLeft - 4'd1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end
  assign txd = txBusy ? txShift[0] : 1'b1;

  // receiver
  typedef enum logic {RX_IDLE, RX_BITS} rxState_e;
  rxState_e          rxState;
  logic [1:0]        rxSync;
  logic              rxS, rxPrev, rxParBit;
  logic [CNT_W-1:0]  rxCnt;
  logic [3:0]        rxIdx;
  logic [2:0]        rxVotes;
  logic [WORD_W-1:0] rxWord;
  logic rxDoneR, rxFeR, rxPeR;
  logic voteNow, isStart, isData, isPar, inWindow;

  assign rxS      = rxSync[1];
  assign voteNow  = (rxVotes[1] & rxVotes[0]) | (rxVotes[1] & rxS) | (rxVotes[0] & rxS);
  assign isStart  = (rxIdx == 4'd0);
  assign isData   = !isStart && (rxIdx <= cfg.nBits);
  assign isPar    = parOn && (rxIdx == cfg.nBits + 4'd1);
  assign inWindow = (rxCnt == midPt - 1'b1) || (rxCnt == midPt) || (rxCnt == midPt + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync   <= '1;
      rxState  <= RX_IDLE;
      rxPrev   <= 1'b1;
      rxCnt    <= '0;
      rxIdx    <= '0;
      rxVotes  <= '1;
      rxWord   <= '0;
      rxParBit <= 1'b0;
      rxDoneR  <= 1'b0;
      rxFeR    <= 1'b0;
      rxPeR    <= 1'b0;
    end else begin
      rxSync  <= {rxSync[0], rxd};
      rxDoneR <= 1'b0;
      if (tick) rxPrev <= rxS;
      case (rxState)
        RX_IDLE: begin
          if (tick && cfg.rxEn && rxPrev && !rxS) begin
            rxState <= RX_BITS;
            rxCnt   <= '0;
            rxIdx   <= '0;
            rxWord  <= '0;
          end
        end
        default: begin
          if (!cfg.rxEn) begin
            rxState <= RX_IDLE;
          end else if (tick) begin
            rxCnt <= (rxCnt == ovsLast) ? '0 : rxCnt + 1'b1;
            if (rxCnt == ovsLast) rxIdx <= rxIdx + 4'd1;
            if (inWindow) rxVotes <= {rxVotes[1:0], rxS};
            if (rxCnt == midPt + 1'b1) begin
              if (isStart) begin
                if (voteNow) rxState <= RX_IDLE;
              end else if (isData) begin
                rxWord[rxIdx - 4'd1] <= voteNow;
              end else if (isPar) begin
                rxParBit <= voteNow;
              end else begin
                rxState <= RX_IDLE;
                rxDoneR <= 1'b1;
                rxFeR   <= !voteNow;
                rxPeR   <= parOn && (wordParity(rxWord, cfg.nBits, cfg.parMode[0]) != rxParBit);
              end
            end
          end
        end
      endcase
    end
  end

  assign dStb.rxDone     = rxDoneR;
  assign dStb.rxWord     = rxWord;
  assign dStb.rxFrameErr = rxFeR;
  assign dStb.rxParErr   = rxPeR;
  assign dStb.txTaken    = txLoad;
  assign dStb.txEnd      = txLastEnd;
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              txDoneAck,
  output logic              irq,
  output lineCfg_t          cfg,
  output ctrlStb_t          cStb,
  input  dpStb_t            dStb,
  output logic [NFLAGS-1:0] statusFlags
);
  localparam int HI_W = DIV_W - 8;

  logic [NFLAGS-1:0] ien;
  logic [2:0]        fmtCode;
  logic [1:0]        parMode;
  logic              twoStop, dbl, txBit8, rxEn, txEn;
  logic [HI_W-1:0]   divStage;
  logic [DIV_W-1:0]  divReg;
  logic [WORD_W-1:0] txHold, rxHold;
  logic txFull, txDone, rxReady, feFlag, ovrFlag, peFlag;
  logic wrHit, rdData0;

  assign wrHit   = wrEn;
  assign rdData0 = rdEn && (addr == A_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ien      <= '0;
      fmtCode  <= 3'b011;
      parMode  <= 2'b00;
      twoStop  <= 1'b0;
      dbl      <= 1'b0;
      txBit8   <= 1'b0;
      rxEn     <= 1'b0;
      txEn     <= 1'b0;
      divStage <= '0;
      divReg   <= '0;
    end else if (wrHit) begin
      case (addr)
        A_IEN:    ien <= wrData[NFLAGS-1:0];
        A_FORMAT: {txBit8, dbl, twoStop, parMode, fmtCode} <= wrData;
        A_DIVHI:  divStage <= wrData[HI_W-1:0];
        A_DIVLO:  divReg <= {divStage, wrData};
        A_ENABLE: {txEn, rxEn} <= wrData[1:0];
        default: ;
      endcase
    end
  end

  // transmit holding register and completion flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
      txDone <= 1'b0;
    end else begin
      if (dStb.txTaken) txFull <= 1'b0;
      if (wrHit && addr == A_DATA) begin
        txHold <= {txBit8, wrData};
        txFull <= 1'b1;
      end
      if (dStb.txEnd && !dStb.txTaken) txDone <= 1'b1;
      else if (txDoneAck || (wrHit && addr == A_STATUS && wrData[2])) txDone <= 1'b0;
    end
  end

  // receive holding register and error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold  <= '0;
      rxReady <= 1'b0;
      feFlag  <= 1'b0;
      ovrFlag <= 1'b0;
      peFlag  <= 1'b0;
    end else if (dStb.rxDone) begin
      if (rxReady && !rdData0) begin
        ovrFlag <= 1'b1;
      end else begin
        rxHold  <= dStb.rxWord;
        feFlag  <= dStb.rxFrameErr;
        peFlag  <= dStb.rxParErr;
        ovrFlag <= 1'b0;
        rxReady <= 1'b1;
      end
    end else if (rdData0) begin
      rxReady <= 1'b0;
    end
  end

  assign statusFlags = {peFlag, ovrFlag, feFlag, txDone, !txFull, rxReady};
  assign irq = |(statusFlags & ien);

  always_comb begin
    case (addr)
      A_DATA:   rdData = rxHold[7:0];
      A_STATUS: rdData = {1'b0, rxHold[8], statusFlags};
      A_IEN:    rdData = {2'b00, ien};
      A_FORMAT: rdData = {txBit8, dbl, twoStop, parMode, fmtCode};
      A_DIVHI:  rdData = {{(8-HI_W){1'b0}}, divReg[DIV_W-1:8]};
      A_DIVLO:  rdData = divReg[7:0];
      A_ENABLE: rdData = {6'd0, txEn, rxEn};
      default:  rdData = 8'h00;
    endcase
  end

  assign cfg.div     = divReg;
  assign cfg.dbl     = dbl;
  assign cfg.nBits   = decodeSize(fmtCode);
  assign cfg.parMode = parMode;
  assign cfg.twoStop = twoStop;
  assign cfg.rxEn    = rxEn;
  assign cStb.txReq  = txFull && txEn;
  assign cStb.txWord = txHold;
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       txDoneAck,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  lineCfg_t          cfg;
  ctrlStb_t          cStb;
  dpStb_t            dStb;
  logic [NFLAGS-1:0] statusFlags;
  logic [DIV_W-1:0]  divNow;
  logic              rxDoneStb, txEndStb;

  assign divNow    = cfg.div;
  assign rxDoneStb = dStb.rxDone;
  assign txEndStb  = dStb.txEnd;

  uart_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .txDoneAck(txDoneAck), .irq(irq), .cfg(cfg), .cStb(cStb),
    .dStb(dStb), .statusFlags(statusFlags)
  );

  uart_datapath #(.OVS_NORM(16), .OVS_FAST(8)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cStb(cStb), .dStb(dStb), .rxd(rxd), .txd(txd)
  );
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk
  import uart_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [2:0]        addr,
  input logic              txDoneAck,
  input logic [NFLAGS-1:0] flags,
  input logic [DIV_W-1:0]  divisor,
  input logic              rxDone,
  input logic              txEnd
);
  AST_DIV_STAGED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_DIVHI) |=> $stable(divisor)); // R2

  AST_EMPTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_DATA) |=> !flags[1]); // R5

  AST_DONE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneAck && !txEnd) |=> !flags[2]); // R6

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> $past(txEnd)); // R6

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_DATA && !rxDone) |=> !flags[0]); // R7

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && flags[0] && !(rdEn && addr == A_DATA)) |=> flags[4]); // R11
endmodule

bind uart_core uart_core_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .txDoneAck(txDoneAck),
  .flags(statusFlags), .divisor(divNow), .rxDone(rxDoneStb), .txEnd(txEndStb)
);

// File: tb/tb_uart_core.sv
module tb_uart_core;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, txDoneAck = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00, rdData;
  logic txd, irq, rxLine;
  logic loopMode = 1'b1, benchLine = 1'b1;
  int checks = 0, fails = 0, curDiv = 0, curDbl = 0;
  logic [15:0] expBits;
  int expLen;
  bit finished = 0;

  localparam logic [2:0] ADATA = 3'd0, ASTAT = 3'd1, AIEN = 3'd2, AFMT = 3'd3,
                         ADHI = 3'd4, ADLO = 3'd5, AEN = 3'd6;

  always #10 clk = ~clk;
  assign rxLine = loopMode ? txd : benchLine;

  uart_core dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .txDoneAck(txDoneAck), .rxd(rxLine), .txd(txd), .irq(irq)
  );

  function automatic int bitP();
    return (curDbl != 0 ? 8 : 16) * (curDiv + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic buildExp(input logic [8:0] w, input int n, input int par, input int st,
                          input bit badPar, input bit badStop);
    logic p;
    int k;
    p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ w[i];
    if (par == 3) p = ~p;
    if (badPar) p = ~p;
    expBits = '1;
    expBits[0] = 1'b0;
    for (int i = 0; i < n; i++) expBits[i+1] = w[i];
    k = n + 1;
    if (par >= 2) begin expBits[k] = p; k++; end
    expBits[k] = badStop ? 1'b0 : 1'b1;
    expLen = k + 1 + st;
  endtask

  task automatic watchTx(input string tag);
    logic [15:0] act;
    int p;
    act = '1;
    p = bitP();
    @(negedge txd);
    repeat (p / 2) @(negedge clk);
    for (int k = 0; k < expLen; k++) begin
      act[k] = txd;
      if (k < expLen - 1) repeat (p) @(negedge clk);
    end
    chk(tag, {16'd0, act}, {16'd0, expBits});
  endtask

  task automatic driveFrame();
    int p;
    p = bitP();
    for (int k = 0; k < expLen; k++) begin
      @(negedge clk); benchLine = expBits[k];
      repeat (p - 1) @(negedge clk);
    end
    benchLine = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic sendTx(input logic [8:0] w, input string tag);
    fork
      wr(ADATA, w[7:0]);
      watchTx(tag);
    join
    repeat (bitP()) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [8:0] w;
    int n, code, idx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(ASTAT, v); chk("R1 status", {24'd0, v}, 32'h02);
    rd(ADLO, v);  chk("R1 divisor", {24'd0, v}, 32'h00);

    wr(AEN, 8'h03);
    // R2 divisor commit on low write, period 16*(3+1)
    wr(ADLO, 8'h03); curDiv = 3;
    wr(AFMT, 8'h03);
    buildExp(9'h0C5, 8, 0, 0, 0, 0);
    sendTx(9'h0C5, "R2 period D=3");
    wr(ADHI, 8'h01);
    rd(ADHI, v); chk("R2 staged high not committed", {24'd0, v}, 32'h00);
    buildExp(9'h03A, 8, 0, 0, 0, 0);
    sendTx(9'h03A, "R2 period after high-only write");
    wr(ADHI, 8'h00); wr(ADLO, 8'h01); curDiv = 1;
    rd(ADATA, v);
    wr(ASTAT, 8'h04);

    // R3 R4 R7 R8 sweep in loopback
    idx = 0;
    for (int dbl = 0; dbl < 2; dbl++) begin
      for (int ci = 0; ci < 6; ci++) begin
        for (int par = 0; par < 4; par++) begin
          for (int st = 0; st < 2; st++) begin
            case (ci)
              0: code = 0; 1: code = 1; 2: code = 2; 3: code = 3; 4: code = 7; default: code = 5;
            endcase
            n = (code == 7) ? 9 : (code < 4) ? code + 5 : 8;
            w = 9'((idx * 73 + 90) % 512);
            idx++;
            curDbl = dbl;
            wr(AFMT, {w[8], 1'(dbl), 1'(st), 2'(par), 3'(code)});
            buildExp(w, n, par, st, 0, 0);
            sendTx(w, "R3 R4 frame waveform");
            rd(ASTAT, v);
            chk("R6 R7 R8 status after frame", {24'd0, v},
                32'h07 | ((n == 9 && w[8]) ? 32'h40 : 32'h00));
            rd(ADATA, v);
            chk("R7 received data", {24'd0, v},
                {24'd0, w[7:0]} & ((n >= 8) ? 32'hFF : ((32'd1 << n) - 1)));
            wr(ASTAT, 8'h04);
          end
        end
      end
    end

    // receive error cases, 8 bits, even parity, one stop
    curDbl = 0;
    loopMode = 1'b0;
    wr(AFMT, 8'h13);
    buildExp(9'h03C, 8, 2, 0, 0, 1); driveFrame();
    rd(ASTAT, v); chk("R9 framing error", {24'd0, v}, 32'h0B);
    rd(ADATA, v); chk("R9 data with framing error", {24'd0, v}, 32'h3C);
    buildExp(9'h0A5, 8, 2, 0, 0, 0); driveFrame();
    rd(ASTAT, v); chk("R9 framing flag renewed", {24'd0, v}, 32'h03);
    rd(ADATA, v);
    buildExp(9'h05A, 8, 2, 0, 1, 0); driveFrame();
    rd(ASTAT, v); chk("R10 parity error", {24'd0, v}, 32'h23);
    rd(ADATA, v);
    buildExp(9'h011, 8, 2, 0, 0, 0); driveFrame();
    buildExp(9'h022, 8, 2, 0, 0, 0); driveFrame();
    rd(ASTAT, v); chk("R11 overrun", {24'd0, v}, 32'h13);
    rd(ADATA, v); chk("R11 unread data kept", {24'd0, v}, 32'h11);
    buildExp(9'h033, 8, 2, 0, 0, 0); driveFrame();
    rd(ASTAT, v); chk("R11 overrun cleared", {24'd0, v}, 32'h03);
    rd(ADATA, v); chk("R11 next data", {24'd0, v}, 32'h33);

    // R12 glitch
    @(negedge clk); benchLine = 1'b0;
    repeat (bitP() / 4) @(negedge clk);
    benchLine = 1'b1;
    repeat (2 * bitP()) @(negedge clk);
    rd(ASTAT, v); chk("R12 glitch rejected", {24'd0, v}, 32'h02);
    buildExp(9'h044, 8, 2, 0, 0, 0); driveFrame();
    rd(ADATA, v); chk("R12 frame after glitch", {24'd0, v}, 32'h44);

    // R14 receiver disabled
    wr(AEN, 8'h02);
    buildExp(9'h055, 8, 2, 0, 0, 0); driveFrame();
    rd(ASTAT, v); chk("R14 rx disabled ignores line", {24'd0, v}, 32'h02);
    wr(AEN, 8'h03);

    // R13 interrupt
    wr(AIEN, 8'h01);
    @(negedge clk); chk("R13 irq masked idle", {31'd0, irq}, 32'd0);
    buildExp(9'h066, 8, 2, 0, 0, 0); driveFrame();
    chk("R13 irq on receive ready", {31'd0, irq}, 32'd1);
    rd(ADATA, v);
    @(negedge clk); chk("R13 irq after read", {31'd0, irq}, 32'd0);
    wr(AIEN, 8'h02);
    @(negedge clk); chk("R13 irq on tx empty", {31'd0, irq}, 32'd1);
    wr(AIEN, 8'h00);

    // R14 transmitter disabled
    wr(AFMT, 8'h03);
    wr(AEN, 8'h01);
    wr(ADATA, 8'h77);
    repeat (5 * bitP()) @(negedge clk);
    chk("R14 tx disabled line idle", {31'd0, txd}, 32'd1);
    rd(ASTAT, v); chk("R14 byte held", {24'd0, v}, 32'h00);
    buildExp(9'h077, 8, 0, 0, 0, 0);
    fork
      wr(AEN, 8'h03);
      watchTx("R14 held byte sent");
    join
    repeat (bitP()) @(negedge clk);
    wr(ASTAT, 8'h04);

    // R5 R6 back to back
    wr(ADATA, 8'hA1);
    rd(ASTAT, v); chk("R5 empty after take", {30'd0, v[2:1]}, 32'h1);
    wr(ADATA, 8'hB2);
    rd(ASTAT, v); chk("R5 second byte waits", {30'd0, v[2:1]}, 32'h0);
    repeat (10 * bitP() + bitP() / 2) @(negedge clk);
    rd(ASTAT, v); chk("R6 no done between frames", {30'd0, v[2:1]}, 32'h1);
    repeat (10 * bitP()) @(negedge clk);
    rd(ASTAT, v); chk("R6 done after last frame", {30'd0, v[2:1]}, 32'h3);
    @(negedge clk); txDoneAck = 1'b1;
    @(negedge clk); txDoneAck = 1'b0;
    rd(ASTAT, v); chk("R6 ack clears done", {30'd0, v[2:1]}, 32'h1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule